// File: doc/BRIEF.md
# Video Expansion Card Address Decoder

This block sits between a 16-bit byte-addressed host bus and the devices on a video expansion card. For each access it picks one target: the write-only sound port, the video processor port pair, a paged firmware ROM, a 256-byte non-volatile RAM, or the palette register bank. It also produces the address each target needs: a 16-bit ROM address built from a 3-bit page number, an 8-bit RAM offset, the video register index and the palette register number.

The firmware, RAM and palette regions all lie inside one 8 KB window, and that window only responds while the card is selected. Inside the window a fixed priority settles the overlaps. The palette comes first. The RAM comes next, but only while RAM access is enabled. Every other address in the window goes to the ROM. The sound and video ports respond only to even addresses, and whether they respond also depends on the access direction.

The host presents an address with a one-cycle setup strobe. All strobes and translated addresses are captured on that cycle and held until the next setup.

Top module: `vcd_addr_decode`

## Requirements
- R1: `sel_sound_o` is asserted only for writes (`rd_i`=0) whose address satisfies (addr AND 0xFF01) = 0x8400.
- R2: `sel_video_o` is asserted for reads with (addr AND 0xFC01) = 0x8800 and for writes with (addr AND 0xFC01) = 0x8C00. `video_reg_o` equals addr shifted right by one bit.
- R3: No firmware-window target (ROM, RAM or palette) is asserted unless `card_sel_i`=1 and (addr AND 0xE000) = 0x4000.
- R4: Inside the active window, (addr AND 0xFFF0) = 0x5FF0 asserts `sel_pal_o`, whatever `ram_en_i` is. `pal_reg_o` equals addr[3:0].
- R5: Inside the active window, an address that is not a palette address and has (addr AND 0xFF00) = 0x5F00 asserts `sel_ram_o` only when `ram_en_i`=1. `ram_addr_o` equals addr[7:0].
- R6: Every other address in the active window asserts `sel_rom_o`. `rom_addr_o` equals {rom_page_i, addr[12:0]}.
- R7: At most one strobe is asserted at any time. An address that matches no target leaves all strobes low.
- R8: Outputs change only on a clock edge where `setup_i`=1 and reflect that cycle's inputs from the next cycle on. While `setup_i`=0 they hold their values.
- R9: Synchronous active-high `rst` clears all strobes and all translated addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_i | input | 1 | Address setup strobe, one cycle per access |
| addr_i | input | 16 | Byte address |
| rd_i | input | 1 | 1 = read, 0 = write |
| card_sel_i | input | 1 | Firmware window enable |
| ram_en_i | input | 1 | Non-volatile RAM enable |
| rom_page_i | input | 3 | ROM page number |
| sel_sound_o | output | 1 | Sound port strobe |
| sel_video_o | output | 1 | Video port strobe |
| sel_rom_o | output | 1 | Firmware ROM strobe |
| sel_ram_o | output | 1 | Non-volatile RAM strobe |
| sel_pal_o | output | 1 | Palette bank strobe |
| video_reg_o | output | 15 | Video register index (addr >> 1) |
| rom_addr_o | output | 16 | Paged ROM address |
| ram_addr_o | output | 8 | RAM byte offset |
| pal_reg_o | output | 4 | Palette register number |

## Verification
The bench sweeps the whole address space in both directions. This catches the faults that only show up in these sweeps: a decoder that drops the low-bit term would answer odd sound or video addresses, and one that ignores direction would send reads to the sound port or writes into the video read range. At the top of the window, addresses 0x5FF0 to 0x5FFF with RAM disabled must still reach the palette. Addresses 0x5F00 to 0x5FEF with RAM disabled must fall through to the ROM. A wrong priority shows up either as two strobes at once or as a RAM strobe while RAM is disabled. Directed cases with the card deselected, with `setup_i` held low and with a reset in mid-run show whether a design leaks window selects, updates outputs between setups, or keeps stale addresses.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam int ADDR_W    = 16;
  localparam int PAGE_W    = 3;
  localparam int ROM_OFF_W = 13;
  localparam int RAM_AW    = 8;
  localparam int PAL_AW    = 4;

  localparam logic [ADDR_W-1:0] SND_MASK = 16'hFF01;
  localparam logic [ADDR_W-1:0] SND_VAL  = 16'h8400;
  localparam logic [ADDR_W-1:0] VID_MASK = 16'hFC01;
  localparam logic [ADDR_W-1:0] VRD_VAL  = 16'h8800;
  localparam logic [ADDR_W-1:0] VWR_VAL  = 16'h8C00;
  localparam logic [ADDR_W-1:0] WIN_MASK = 16'hE000;
  localparam logic [ADDR_W-1:0] WIN_VAL  = 16'h4000;
  localparam logic [ADDR_W-1:0] RAM_MASK = 16'hFF00;
  localparam logic [ADDR_W-1:0] RAM_VAL  = 16'h5F00;
  localparam logic [ADDR_W-1:0] PAL_MASK = 16'hFFF0;
  localparam logic [ADDR_W-1:0] PAL_VAL  = 16'h5FF0;

  localparam int N_TGT = 5;
  typedef enum int {TGT_SOUND = 4, TGT_VIDEO = 3, TGT_ROM = 2, TGT_RAM = 1, TGT_PAL = 0} tgt_idx_e;
endpackage

// File: rtl/vcd_bus_match.sv
module vcd_bus_match
  import vcd_pkg::*;
#(
  parameter int                AW       = ADDR_W,
  parameter logic [AW-1:0]     S_MASK   = SND_MASK,
  parameter logic [AW-1:0]     S_VAL    = SND_VAL,
  parameter logic [AW-1:0]     V_MASK   = VID_MASK,
  parameter logic [AW-1:0]     V_RD_VAL = VRD_VAL,
  parameter logic [AW-1:0]     V_WR_VAL = VWR_VAL
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  output logic          snd_hit,
  output logic          vid_hit
);
  logic [AW-1:0] s_bits, v_bits;
  always_comb begin
    s_bits  = addr & S_MASK;
    v_bits  = addr & V_MASK;
    snd_hit = !rd && (s_bits == S_VAL);
    vid_hit = rd ? (v_bits == V_RD_VAL) : (v_bits == V_WR_VAL);
  end
endmodule

// File: rtl/vcd_window_resolve.sv
module vcd_window_resolve
  import vcd_pkg::*;
#(
  parameter int            AW     = ADDR_W,
  parameter logic [AW-1:0] W_MASK = WIN_MASK,
  parameter logic [AW-1:0] W_VAL  = WIN_VAL,
  parameter logic [AW-1:0] R_MASK = RAM_MASK,
  parameter logic [AW-1:0] R_VAL  = RAM_VAL,
  parameter logic [AW-1:0] P_MASK = PAL_MASK,
  parameter logic [AW-1:0] P_VAL  = PAL_VAL
) (
  input  logic [AW-1:0] addr,
  input  logic          card_sel,
  input  logic          ram_en,
  output logic          rom_hit,
  output logic          ram_hit,
  output logic          pal_hit
);
  logic in_win, pal_zone, ram_zone;
  always_comb begin
    in_win   = card_sel && ((addr & W_MASK) == W_VAL);
    pal_zone = (addr & P_MASK) == P_VAL;
    ram_zone = (addr & R_MASK) == R_VAL;
    // fixed priority: palette, then enabled RAM, then ROM
    pal_hit  = in_win && pal_zone;
    ram_hit  = in_win && !pal_zone && ram_zone && ram_en;
    rom_hit  = in_win && !pal_zone && !(ram_zone && ram_en);
  end
endmodule

// File: rtl/vcd_addr_xlate.sv
module vcd_addr_xlate
  import vcd_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int PW    = PAGE_W,
  parameter int OFF_W = ROM_OFF_W,
  parameter int RW    = RAM_AW,
  parameter int PLW   = PAL_AW,
  localparam int ROM_W = PW + OFF_W
) (
  input  logic [AW-1:0]    addr,
  input  logic [PW-1:0]    page,
  output logic [ROM_W-1:0] rom_addr,
  output logic [RW-1:0]    ram_addr,
  output logic [AW-2:0]    video_reg,
  output logic [PLW-1:0]   pal_reg
);
  always_comb begin
    rom_addr  = {page, addr[OFF_W-1:0]};
    ram_addr  = addr[RW-1:0];
    video_reg = addr[AW-1:1];
    pal_reg   = addr[PLW-1:0];
  end
endmodule

// File: rtl/vcd_addr_decode.sv
module vcd_addr_decode
  import vcd_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int PW    = PAGE_W,
  parameter int OFF_W = ROM_OFF_W,
  parameter int RW    = RAM_AW,
  parameter int PLW   = PAL_AW,
  localparam int ROM_W = PW + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             card_sel_i,
  input  logic             ram_en_i,
  input  logic [PW-1:0]    rom_page_i,
  output logic             sel_sound_o,
  output logic             sel_video_o,
  output logic             sel_rom_o,
  output logic             sel_ram_o,
  output logic             sel_pal_o,
  output logic [AW-2:0]    video_reg_o,
  output logic [ROM_W-1:0] rom_addr_o,
  output logic [RW-1:0]    ram_addr_o,
  output logic [PLW-1:0]   pal_reg_o
);
  logic             snd_hit, vid_hit, rom_hit, ram_hit, pal_hit;
  logic [N_TGT-1:0] hit_vec, sel_q;
  logic [ROM_W-1:0] rom_d;
  logic [RW-1:0]    ram_d;
  logic [AW-2:0]    vid_d;
  logic [PLW-1:0]   pal_d;

  vcd_bus_match #(.AW(AW)) u_bus (
    .addr(addr_i), .rd(rd_i), .snd_hit(snd_hit), .vid_hit(vid_hit)
  );

  vcd_window_resolve #(.AW(AW)) u_win (
    .addr(addr_i), .card_sel(card_sel_i), .ram_en(ram_en_i),
    .rom_hit(rom_hit), .ram_hit(ram_hit), .pal_hit(pal_hit)
  );

  vcd_addr_xlate #(.AW(AW), .PW(PW), .OFF_W(OFF_W), .RW(RW), .PLW(PLW)) u_xl (
    .addr(addr_i), .page(rom_page_i), .rom_addr(rom_d), .ram_addr(ram_d),
    .video_reg(vid_d), .pal_reg(pal_d)
  );

  always_comb begin
    hit_vec            = '0;
    hit_vec[TGT_SOUND] = snd_hit;
    hit_vec[TGT_VIDEO] = vid_hit;
    hit_vec[TGT_ROM]   = rom_hit;
    hit_vec[TGT_RAM]   = ram_hit;
    hit_vec[TGT_PAL]   = pal_hit;
  end

  // one capture flop per strobe
  for (genvar g = 0; g < N_TGT; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)          sel_q[g] <= 1'b0;
      else if (setup_i) sel_q[g] <= hit_vec[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      video_reg_o <= '0;
      rom_addr_o  <= '0;
      ram_addr_o  <= '0;
      pal_reg_o   <= '0;
    end else if (setup_i) begin
      video_reg_o <= vid_d;
      rom_addr_o  <= rom_d;
      ram_addr_o  <= ram_d;
      pal_reg_o   <= pal_d;
    end
  end

  assign sel_sound_o = sel_q[TGT_SOUND];
  assign sel_video_o = sel_q[TGT_VIDEO];
  assign sel_rom_o   = sel_q[TGT_ROM];
  assign sel_ram_o   = sel_q[TGT_RAM];
  assign sel_pal_o   = sel_q[TGT_PAL];
endmodule

// File: rtl/vcd_addr_decode_chk.sv
module vcd_addr_decode_chk (
  input logic clk,
  input logic rst,
  input logic setup_i,
  input logic rd_i,
  input logic card_sel_i,
  input logic ram_en_i,
  input logic sel_sound_o,
  input logic sel_video_o,
  input logic sel_rom_o,
  input logic sel_ram_o,
  input logic sel_pal_o
);
  logic [4:0] strobes;
  assign strobes = {sel_sound_o, sel_video_o, sel_rom_o, sel_ram_o, sel_pal_o};

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst) $onehot0(strobes)); // R7
  AST_SOUND_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (setup_i && rd_i) |=> !sel_sound_o); // R1
  AST_WINDOW_CARD: assert property (@(posedge clk) disable iff (rst)
    (setup_i && !card_sel_i) |=> !(sel_rom_o || sel_ram_o || sel_pal_o)); // R3
  AST_RAM_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (setup_i && !ram_en_i) |=> !sel_ram_o); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !setup_i |=> $stable(strobes)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (strobes == 5'b0)); // R9
endmodule

bind vcd_addr_decode vcd_addr_decode_chk u_chk (
  .clk(clk), .rst(rst), .setup_i(setup_i), .rd_i(rd_i),
  .card_sel_i(card_sel_i), .ram_en_i(ram_en_i),
  .sel_sound_o(sel_sound_o), .sel_video_o(sel_video_o), .sel_rom_o(sel_rom_o),
  .sel_ram_o(sel_ram_o), .sel_pal_o(sel_pal_o)
);

// File: tb/vcd_addr_decode_test.sv
module vcd_addr_decode_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, card_sel_i = 1'b0, ram_en_i = 1'b0;
  logic [2:0]  rom_page_i = '0;
  logic        sel_sound_o, sel_video_o, sel_rom_o, sel_ram_o, sel_pal_o;
  logic [14:0] video_reg_o;
  logic [15:0] rom_addr_o;
  logic [7:0]  ram_addr_o;
  logic [3:0]  pal_reg_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcd_addr_decode uut (
    .clk(clk), .rst(rst), .setup_i(setup_i), .addr_i(addr_i), .rd_i(rd_i),
    .card_sel_i(card_sel_i), .ram_en_i(ram_en_i), .rom_page_i(rom_page_i),
    .sel_sound_o(sel_sound_o), .sel_video_o(sel_video_o), .sel_rom_o(sel_rom_o),
    .sel_ram_o(sel_ram_o), .sel_pal_o(sel_pal_o), .video_reg_o(video_reg_o),
    .rom_addr_o(rom_addr_o), .ram_addr_o(ram_addr_o), .pal_reg_o(pal_reg_o)
  );

  // vector: {addr[15:0], rd, card, ram_en, page[2:0], strobes{snd,vid,rom,ram,pal}}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {16'h8400, 1'b0, 1'b0, 1'b0, 3'd0, 5'b10000},  // R1 write hit
    {16'h8400, 1'b1, 1'b0, 1'b0, 3'd0, 5'b00000},  // R1 read ignored
    {16'h8401, 1'b0, 1'b0, 1'b0, 3'd0, 5'b00000},  // R1 odd
    {16'h84FE, 1'b0, 1'b0, 1'b0, 3'd0, 5'b10000},  // R1
    {16'h8802, 1'b1, 1'b0, 1'b0, 3'd0, 5'b01000},  // R2 read range
    {16'h8802, 1'b0, 1'b0, 1'b0, 3'd0, 5'b00000},  // R2 write in read range
    {16'h8C06, 1'b0, 1'b0, 1'b0, 3'd0, 5'b01000},  // R2 write range
    {16'h8C06, 1'b1, 1'b0, 1'b0, 3'd0, 5'b00000},  // R2
    {16'h4000, 1'b1, 1'b1, 1'b0, 3'd5, 5'b00100},  // R6
    {16'h4000, 1'b1, 1'b0, 1'b0, 3'd5, 5'b00000},  // R3 card off
    {16'h5F10, 1'b0, 1'b1, 1'b1, 3'd2, 5'b00010},  // R5 enabled
    {16'h5F10, 1'b0, 1'b1, 1'b0, 3'd2, 5'b00100},  // R5 disabled -> ROM
    {16'h5FF4, 1'b1, 1'b1, 1'b0, 3'd1, 5'b00001},  // R4 palette w/o RAM en
    {16'h5FF4, 1'b1, 1'b1, 1'b1, 3'd1, 5'b00001},  // R4 palette over RAM
    {16'h5FF4, 1'b1, 1'b0, 1'b1, 3'd1, 5'b00000},  // R3
    {16'h6000, 1'b1, 1'b1, 1'b1, 3'd7, 5'b00000}   // R7 no target
  };

  function automatic logic [4:0] ref_sel(input logic [15:0] a, input logic rd,
                                         input logic card, input logic ren);
    logic win, pal, ram, rom, snd, vid;
    win = card && (a[15:13] == 3'b010);
    pal = win && (a[15:4] == 12'h5FF);
    ram = win && !pal && ren && (a[15:8] == 8'h5F);
    rom = win && !pal && !ram;
    snd = !rd && (a[15:8] == 8'h84) && !a[0];
    vid = !a[0] && (a[15:10] == (rd ? 6'b100010 : 6'b100011));
    return {snd, vid, rom, ram, pal};
  endfunction

  function automatic string tag_of(input logic [4:0] s);
    if (s[4]) return "R1";
    if (s[3]) return "R2";
    if (s[0]) return "R4";
    if (s[1]) return "R5";
    if (s[2]) return "R6";
    return "R7";
  endfunction

  task automatic check_out(input string tag, input logic [4:0] exp_s,
                           input logic [15:0] a, input logic [2:0] pg);
    logic [4:0] got;
    got = {sel_sound_o, sel_video_o, sel_rom_o, sel_ram_o, sel_pal_o};
    checks++;
    if (got !== exp_s || video_reg_o !== a[15:1] || rom_addr_o !== {pg, a[12:0]}
        || ram_addr_o !== a[7:0] || pal_reg_o !== a[3:0]) begin
      fails++;
      $display("FAIL %s addr=%h strobes=%b exp=%b vreg=%h/%h rom=%h/%h ram=%h/%h pal=%h/%h",
               tag, a, got, exp_s, video_reg_o, a[15:1], rom_addr_o, {pg, a[12:0]},
               ram_addr_o, a[7:0], pal_reg_o, a[3:0]);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rd, input logic card,
                       input logic ren, input logic [2:0] pg);
    addr_i = a; rd_i = rd; card_sel_i = card; ram_en_i = ren; rom_page_i = pg;
    setup_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] hold_s;
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if ({sel_sound_o, sel_video_o, sel_rom_o, sel_ram_o, sel_pal_o, rom_addr_o} !== '0) begin
      fails++;
      $display("FAIL R9 reset strobes=%b rom=%h exp=0", {sel_sound_o, sel_video_o,
               sel_rom_o, sel_ram_o, sel_pal_o}, rom_addr_o);
    end
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      a = VEC[i][26:11];
      drive(a, VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:5]);
      check_out(tag_of(VEC[i][4:0]), VEC[i][4:0], a, VEC[i][7:5]);
    end

    // full sweep: reads with RAM enabled, writes with RAM disabled
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 65536; k++) begin
        logic [15:0] a;
        logic [2:0]  pg;
        logic [4:0]  e;
        a  = 16'(k);
        pg = a[2:0] ^ 3'b101;
        e  = ref_sel(a, pass == 0, 1'b1, pass == 0);
        drive(a, pass == 0, 1'b1, pass == 0, pg);
        check_out(tag_of(e), e, a, pg);
      end
    end

    // R8 hold while setup low
    drive(16'h5FF2, 1'b1, 1'b1, 1'b0, 3'd3);
    hold_s = {sel_sound_o, sel_video_o, sel_rom_o, sel_ram_o, sel_pal_o};
    setup_i = 1'b0; addr_i = 16'h8400; rd_i = 1'b0; rom_page_i = 3'd6;
    repeat (3) @(negedge clk);
    check_out("R8", hold_s, 16'h5FF2, 3'd3);
    // R8 one-cycle latency
    drive(16'h8400, 1'b0, 1'b0, 1'b0, 3'd6);
    setup_i = 1'b0;
    check_out("R8", 5'b10000, 16'h8400, 3'd6);

    // R9 mid-run reset clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_out("R9", 5'b00000, 16'h0000, 3'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule